// File: doc/BRIEF.md
# Serially Loaded Branch Sequencer

This block sequences instruction fetch for a one-bit processor core that has no program counter of its own. A program counter steps through an external program store one word per clock. Each fetched byte is split into an opcode field and a direct operand address field, both handed to the core in the same cycle the byte arrives.

The core has only a single data bit, so a branch target cannot be written in one go. Instead the core runs a series of store instructions to the address mapped to a destination shift register, which takes one bit per store. Once the whole target has been shifted in, the core raises a jump pulse and the counter takes the register's value at the next clock. All widths, the shift direction and the field order within the program word are parameters.

Top module: `seq_branch_fetch`

## Requirements
- R1: While `rst_n` is low, the program counter and the destination register are both held at zero. The first `rom_addr` after release is 0, and a jump taken at once also leads to address 0.
- R2: On every clock edge without `jump_pulse`, `rom_addr` increases by one. It wraps from 16'hFFFF to 16'h0000.
- R3: On a clock edge with `jump_pulse` high, `rom_addr` takes the value the destination register held before that edge. No extra increment is applied in that cycle.
- R4: On a clock edge with both `dest_sel` and `shift_stb` high, the destination register shifts by one and `dbit` enters at bit 0. After 16 such stores, the first bit stored sits at bit 15 (most significant bit first).
- R5: A clock edge where `dest_sel` or `shift_stb` is low leaves the destination register unchanged, whatever `dbit` is.
- R6: `opcode` equals `rom_word[7:4]` and `operand` equals `rom_word[3:0]`, combinationally and in the same cycle.
- R7: When a jump and a store fall on the same edge, the jump uses the register value from before the shift, and the shift still takes place.
- R8: When more than 16 bits are stored, the oldest bits leave at the top, and the register holds the last 16 bits stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbit | input | 1 | Data bit from the core |
| dest_sel | input | 1 | The store address decodes to the destination register |
| shift_stb | input | 1 | Store strobe from the core |
| jump_pulse | input | 1 | Commit the destination register to the program counter |
| rom_word | input | 8 | Program byte read at `rom_addr` |
| rom_addr | output | 16 | Program counter driving the program store |
| opcode | output | 4 | Opcode field of the current program byte |
| operand | output | 4 | Direct operand address field of the current program byte |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and register, most-significant-bit-first shifting, and the opcode in the upper nibble. A 16-bit counter is small enough to reach the all-ones address with one jump, so the wrap to zero is checked directly. Loading a 20-bit stream checks that the oldest bits are dropped at the top. Since the destination register is only visible through jumps, every load is read back by committing it and watching the fetch address that follows.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic {
      SHIFT_LSB_IN = 1'b0,
      SHIFT_MSB_IN = 1'b1
   } shift_order_e;

   typedef enum logic {
      OPC_LOW  = 1'b0,
      OPC_HIGH = 1'b1
   } field_order_e;
endpackage

// File: rtl/seq_dest_shifter.sv
module seq_dest_shifter #(
   parameter int                   WIDTH = 16,
   parameter seq_pkg::shift_order_e ORDER = seq_pkg::SHIFT_MSB_IN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] dest_q
);
   logic [WIDTH-1:0] dest_nx;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_dest_shifter: WIDTH must be at least 2");
      end
      if (ORDER == seq_pkg::SHIFT_MSB_IN) begin : g_msb_first
         always_comb dest_nx = {dest_q[WIDTH-2:0], din};
      end else begin : g_lsb_first
         always_comb dest_nx = {din, dest_q[WIDTH-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_q <= '0;
      end else if (shift_en) begin
         dest_q <= dest_nx;
      end
   end
endmodule

// File: rtl/seq_prog_counter.sv
module seq_prog_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] pc_q
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("seq_prog_counter: WIDTH must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (load) begin
         pc_q <= load_val;
      end else begin
         pc_q <= pc_q + STEP;
      end
   end
endmodule

// File: rtl/seq_word_split.sv
module seq_word_split #(
   parameter int                   WORD_W = 8,
   parameter int                   OP_W   = 4,
   parameter seq_pkg::field_order_e FIELDS = seq_pkg::OPC_HIGH,
   localparam int                  ADDR_W = WORD_W - OP_W
) (
   input  logic [WORD_W-1:0] word,
   output logic [OP_W-1:0]   opc,
   output logic [ADDR_W-1:0] opnd
);
   generate
      if (OP_W < 1 || OP_W >= WORD_W) begin : g_bad_split
         $error("seq_word_split: OP_W must leave room for an operand");
      end
      if (FIELDS == seq_pkg::OPC_HIGH) begin : g_opc_high
         assign opc  = word[WORD_W-1 -: OP_W];
         assign opnd = word[ADDR_W-1:0];
      end else begin : g_opc_low
         assign opc  = word[OP_W-1:0];
         assign opnd = word[WORD_W-1 -: ADDR_W];
      end
   endgenerate
endmodule

// File: rtl/seq_branch_fetch.sv
module seq_branch_fetch #(
   parameter int                   PC_W   = 16,
   parameter int                   WORD_W = 8,
   parameter int                   OP_W   = 4,
   parameter seq_pkg::shift_order_e ORDER  = seq_pkg::SHIFT_MSB_IN,
   parameter seq_pkg::field_order_e FIELDS = seq_pkg::OPC_HIGH,
   localparam int                  ADDR_W = WORD_W - OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbit,
   input  logic              dest_sel,
   input  logic              shift_stb,
   input  logic              jump_pulse,
   input  logic [WORD_W-1:0] rom_word,
   output logic [PC_W-1:0]   rom_addr,
   output logic [OP_W-1:0]   opcode,
   output logic [ADDR_W-1:0] operand
);
   logic [PC_W-1:0] dest_q;
   logic            store_hit;

   assign store_hit = dest_sel & shift_stb;

   seq_dest_shifter #(.WIDTH(PC_W), .ORDER(ORDER)) i_dest (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (store_hit),
      .din      (dbit),
      .dest_q   (dest_q)
   );

   seq_prog_counter #(.WIDTH(PC_W)) i_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (jump_pulse),
      .load_val (dest_q),
      .pc_q     (rom_addr)
   );

   seq_word_split #(.WORD_W(WORD_W), .OP_W(OP_W), .FIELDS(FIELDS)) i_split (
      .word (rom_word),
      .opc  (opcode),
      .opnd (operand)
   );
endmodule

// File: rtl/seq_branch_fetch_chk.sv
module seq_branch_fetch_chk #(
   parameter int                   PC_W   = 16,
   parameter int                   WORD_W = 8,
   parameter int                   OP_W   = 4,
   parameter seq_pkg::shift_order_e ORDER  = seq_pkg::SHIFT_MSB_IN,
   parameter seq_pkg::field_order_e FIELDS = seq_pkg::OPC_HIGH,
   localparam int                  ADDR_W = WORD_W - OP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbit,
   input logic              dest_sel,
   input logic              shift_stb,
   input logic              jump_pulse,
   input logic [WORD_W-1:0] rom_word,
   input logic [PC_W-1:0]   rom_addr,
   input logic [OP_W-1:0]   opcode,
   input logic [ADDR_W-1:0] operand,
   input logic [PC_W-1:0]   dest_q
);
   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rom_addr == '0 && dest_q == '0)); // R1

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !jump_pulse |=> rom_addr == $past(rom_addr) + PC_W'(1)); // R2

   AST_JUMP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      jump_pulse |=> rom_addr == $past(dest_q)); // R3

   AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(dest_sel && shift_stb) |=> $stable(dest_q)); // R5

   generate
      if (ORDER == seq_pkg::SHIFT_MSB_IN) begin : g_msb
         AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (dest_sel && shift_stb) |=> dest_q[0] == $past(dbit)); // R4
      end else begin : g_lsb
         AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (dest_sel && shift_stb) |=> dest_q[PC_W-1] == $past(dbit)); // R4
      end
      if (FIELDS == seq_pkg::OPC_HIGH) begin : g_fhi
         always_comb begin
            if (rst_n) begin
               AST_FIELD_SPLIT: assert ({opcode, operand} == rom_word); // R6
            end
         end
      end else begin : g_flo
         always_comb begin
            if (rst_n) begin
               AST_FIELD_SPLIT: assert ({operand, opcode} == rom_word); // R6
            end
         end
      end
   endgenerate
endmodule

bind seq_branch_fetch seq_branch_fetch_chk #(
   .PC_W(PC_W), .WORD_W(WORD_W), .OP_W(OP_W), .ORDER(ORDER), .FIELDS(FIELDS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbit       (dbit),
   .dest_sel   (dest_sel),
   .shift_stb  (shift_stb),
   .jump_pulse (jump_pulse),
   .rom_word   (rom_word),
   .rom_addr   (rom_addr),
   .opcode     (opcode),
   .operand    (operand),
   .dest_q     (dest_q)
);

// File: tb/test_seq_branch_fetch.sv
module test_seq_branch_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbit = 1'b0;
   logic        dest_sel = 1'b0;
   logic        shift_stb = 1'b0;
   logic        jump_pulse = 1'b0;
   logic [7:0]  rom_word = 8'h00;
   logic [15:0] rom_addr;
   logic [3:0]  opcode;
   logic [3:0]  operand;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // {jump target, program byte}
   localparam logic [23:0] VEC [0:5] = '{
      24'h1234_A5, 24'h8001_3C, 24'h0000_F0,
      24'hBEEF_0F, 24'h7FFE_96, 24'h5A5A_E1
   };

   seq_branch_fetch i_seq_branch_fetch (
      .clk(clk), .rst_n(rst_n), .dbit(dbit), .dest_sel(dest_sel),
      .shift_stb(shift_stb), .jump_pulse(jump_pulse), .rom_word(rom_word),
      .rom_addr(rom_addr), .opcode(opcode), .operand(operand)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic store_bit(input logic b, input logic sel, input logic stb);
      dbit = b; dest_sel = sel; shift_stb = stb;
      @(negedge clk);
      dbit = 1'b0; dest_sel = 1'b0; shift_stb = 1'b0;
   endtask

   task automatic load_target(input logic [15:0] t);
      for (int i = 15; i >= 0; i--) store_bit(t[i], 1'b1, 1'b1);
   endtask

   task automatic do_jump();
      jump_pulse = 1'b1;
      @(negedge clk);
      jump_pulse = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] t;
      logic [15:0] a;
      repeat (3) @(negedge clk);
      check("R1 addr in reset", rom_addr, 16'h0000);
      rst_n = 1'b1;
      #1 check("R1 addr after release", rom_addr, 16'h0000);
      do_jump();
      check("R1 cleared register via jump", rom_addr, 16'h0000);

      // table walk: fields, load, jump, advance
      foreach (VEC[k]) begin
         t = VEC[k][23:8];
         rom_word = VEC[k][7:0];
         #1;
         check("R6 opcode", {12'h0, opcode}, {12'h0, VEC[k][7:4]});
         check("R6 operand", {12'h0, operand}, {12'h0, VEC[k][3:0]});
         load_target(t);
         do_jump();
         check("R3 jump target", rom_addr, t);
         @(negedge clk);
         check("R2 advance after jump", rom_addr, t + 16'd1);
         @(negedge clk);
         check("R2 second advance", rom_addr, t + 16'd2);
      end

      // R2 wrap at top of address space
      load_target(16'hFFFF);
      do_jump();
      check("R2 at top", rom_addr, 16'hFFFF);
      @(negedge clk);
      check("R2 wrap to zero", rom_addr, 16'h0000);

      // R5 stores without select or strobe are ignored
      load_target(16'h0F0F);
      store_bit(1'b1, 1'b0, 1'b1);
      store_bit(1'b1, 1'b1, 1'b0);
      store_bit(1'b1, 1'b0, 1'b0);
      do_jump();
      check("R5 ignored stores", rom_addr, 16'h0F0F);

      // R7 jump and store on the same edge
      load_target(16'hC3A5);
      dbit = 1'b1; dest_sel = 1'b1; shift_stb = 1'b1; jump_pulse = 1'b1;
      @(negedge clk);
      dbit = 1'b0; dest_sel = 1'b0; shift_stb = 1'b0; jump_pulse = 1'b0;
      check("R7 jump sees old value", rom_addr, 16'hC3A5);
      do_jump();
      check("R7 shift still applied", rom_addr, 16'h874B);

      // R4 first stored bit ends at MSB
      a = 16'h8000;
      load_target(a);
      do_jump();
      check("R4 first bit at MSB", rom_addr, 16'h8000);

      // R8 overlong load keeps the last 16 bits
      for (int i = 19; i >= 0; i--) store_bit(((20'hF1234 >> i) & 20'h1) != 0, 1'b1, 1'b1);
      do_jump();
      check("R8 overlong load", rom_addr, 16'h1234);

      // R1 reset in mid-run clears both registers
      load_target(16'hAAAA);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", rom_addr, 16'h0000);
      rst_n = 1'b1;
      do_jump();
      check("R1 register cleared by reset", rom_addr, 16'h0000);

      finish_run();
   end
endmodule